// File: doc/BRIEF.md
# GPIO Output Signal Routing Matrix

This block decides, for every GPIO pin of a chip, what value the pin carries and whether the pin is driven. Each pin has its own configuration. The configuration picks one of the peripheral output signals by number, or falls back to a bit of a software-owned output register. The block then applies an optional value inversion and chooses the output enable. The enable comes either from the chosen peripheral's own enable line or from a software-owned enable register, and it can also be inverted. A per-pin driver mode then turns the result into either a push-pull drive or an open-drain drive. Pad electrical behaviour is handled elsewhere.

The software output and enable registers live inside the block. A single write port updates them. Each write carries a target (value or enable), an operation (plain write, write-one-to-set, write-one-to-clear or no effect) and a bank index. Bank 0 covers the first 32 pins and bank 1 covers the remaining pins. Both pin outputs come from registers, so a pin's value and its enable always change on the same clock edge.

Top module: `gpom_matrix`

## Requirements
- R1: With a pin's 9-bit select below 256 (the number of peripheral signals) and no inversion or open-drain, the pin value equals peripheral output signal number select.
- R2: Any select value from 256 to 511 routes the pin's own bit of the software value register to the pin instead of a peripheral signal.
- R3: When the pin's value-invert bit is 1, the routed value is complemented before it reaches the pin.
- R4: The chosen enable is the pin's bit of the software enable register when the select is 256 or higher, or when the pin's enable-source bit is 1. Otherwise it is peripheral enable signal number select.
- R5: When the pin's enable-invert bit is 1, the chosen enable is complemented.
- R6: With the driver-mode bit at 0 (push-pull), pin_val is the final value and pin_oe is the final enable. With it at 1 (open-drain), pin_val is 0 and pin_oe is 1 only when the final enable is 1 and the final value is 0.
- R7: A software write updates only the pins of the addressed bank. Operation code 0 copies the data bits, 1 sets the bits where data is 1, 2 clears the bits where data is 1, and 3 changes nothing. Target 0 is the value register and target 1 is the enable register. Bank 0 maps data bit i to pin i. Bank 1 maps data bit i to pin 32+i, and data bits above the bank's width are ignored.
- R8: pin_val and pin_oe follow a change of peripheral or configuration inputs one clock edge later. They follow a software write two edges after the edge that samples the write.
- R9: During and directly after reset, both software registers and both pin outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_out | input | NUM_SIGS | Peripheral output signals |
| periph_oe | input | NUM_SIGS | Peripheral output-enable signals |
| cfg_sel | input | NUM_PINS*SEL_W | Per-pin source select, pin p at bits [p*SEL_W +: SEL_W] |
| cfg_out_inv | input | NUM_PINS | Per-pin value invert |
| cfg_oe_src | input | NUM_PINS | Per-pin enable source, 1 = software enable register |
| cfg_oe_inv | input | NUM_PINS | Per-pin enable invert |
| cfg_od | input | NUM_PINS | Per-pin driver mode, 1 = open-drain |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_tgt | input | 1 | 0 = value register, 1 = enable register |
| sw_wr_op | input | 2 | 0 write, 1 set, 2 clear, 3 no effect |
| sw_wr_bank | input | BANK_SEL_W | Bank index of the write |
| sw_wr_data | input | BANK_W | Write data for the addressed bank |
| pin_val | output | NUM_PINS | Registered pin value |
| pin_oe | output | NUM_PINS | Registered pin tristate enable, 1 = drive |

## Verification
The bench builds the block with its default parameters: 40 pins, 256 peripheral signals, a 9-bit select and 32-bit banks. This size reaches the last peripheral index 255, the fallback code 256 and its alias 511. It also reaches a partially filled upper bank, whose data bits above bit 7 must be dropped. With two banks, a write to one bank can be checked for leaving the other bank alone. Bank 1 also contains pin 39, the highest pin.

// File: rtl/gpom_pkg.sv
package gpom_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_HOLD  = 2'd3
    } wr_op_e;

    localparam logic TGT_VAL = 1'b0;
    localparam logic TGT_OE  = 1'b1;

    function automatic logic apply_op(input wr_op_e op, input logic old_bit, input logic dat);
        logic r;
        unique case (op)
            OP_WRITE: r = dat;
            OP_SET:   r = old_bit | dat;
            OP_CLEAR: r = old_bit & ~dat;
            default:  r = old_bit;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpom_swreg.sv
module gpom_swreg
    import gpom_pkg::*;
#(
    parameter int NUM_PINS   = 40,
    parameter int BANK_W     = 32,
    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_tgt,
    input  logic [1:0]            wr_op,
    input  logic [BANK_SEL_W-1:0] wr_bank,
    input  logic [BANK_W-1:0]     wr_data,
    output logic [NUM_PINS-1:0]   sw_val,
    output logic [NUM_PINS-1:0]   sw_oe
);

    typedef struct packed {
        logic [NUM_PINS-1:0] val;
        logic [NUM_PINS-1:0] oe;
    } swreg_t;

    swreg_t reg_d, reg_q;
    wr_op_e op_w;

    assign op_w = wr_op_e'(wr_op);

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_bank == BANK_SEL_W'(p / BANK_W)) begin
                    if (wr_tgt == TGT_VAL) begin
                        reg_d.val[p] = apply_op(op_w, reg_q.val[p], wr_data[p % BANK_W]);
                    end else begin
                        reg_d.oe[p] = apply_op(op_w, reg_q.oe[p], wr_data[p % BANK_W]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign sw_val = reg_q.val;
    assign sw_oe  = reg_q.oe;

endmodule

// File: rtl/gpom_pin_mux.sv
module gpom_pin_mux #(
    parameter int NUM_SIGS  = 256,
    parameter int SEL_W     = 9,
    localparam int SIG_IDX_W = $clog2(NUM_SIGS)
) (
    input  logic [NUM_SIGS-1:0] periph_out,
    input  logic [NUM_SIGS-1:0] periph_oe,
    input  logic [SEL_W-1:0]    sel,
    input  logic                out_inv,
    input  logic                oe_src,
    input  logic                oe_inv,
    input  logic                od,
    input  logic                sw_val,
    input  logic                sw_oe,
    output logic                drv_val,
    output logic                drv_oe
);

    logic                 use_sw;
    logic [SIG_IDX_W-1:0] idx;
    logic                 raw_val, raw_oe, fin_val, fin_oe;

    always_comb begin
        use_sw  = (sel >= SEL_W'(NUM_SIGS));
        idx     = sel[SIG_IDX_W-1:0];
        raw_val = use_sw ? sw_val : periph_out[idx];
        raw_oe  = (use_sw || oe_src) ? sw_oe : periph_oe[idx];
        fin_val = raw_val ^ out_inv;
        fin_oe  = raw_oe ^ oe_inv;
        if (od) begin
            drv_val = 1'b0;
            drv_oe  = fin_oe & ~fin_val;
        end else begin
            drv_val = fin_val;
            drv_oe  = fin_oe;
        end
    end

endmodule

// File: rtl/gpom_matrix.sv
module gpom_matrix #(
    parameter int NUM_PINS   = 40,
    parameter int NUM_SIGS   = 256,
    parameter int SEL_W      = 9,
    parameter int BANK_W     = 32,
    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SIGS-1:0]       periph_out,
    input  logic [NUM_SIGS-1:0]       periph_oe,
    input  logic [NUM_PINS*SEL_W-1:0] cfg_sel,
    input  logic [NUM_PINS-1:0]       cfg_out_inv,
    input  logic [NUM_PINS-1:0]       cfg_oe_src,
    input  logic [NUM_PINS-1:0]       cfg_oe_inv,
    input  logic [NUM_PINS-1:0]       cfg_od,
    input  logic                      sw_wr_en,
    input  logic                      sw_wr_tgt,
    input  logic [1:0]                sw_wr_op,
    input  logic [BANK_SEL_W-1:0]     sw_wr_bank,
    input  logic [BANK_W-1:0]         sw_wr_data,
    output logic [NUM_PINS-1:0]       pin_val,
    output logic [NUM_PINS-1:0]       pin_oe
);

    typedef struct packed {
        logic [NUM_PINS-1:0] val;
        logic [NUM_PINS-1:0] oe;
    } pins_t;

    logic [NUM_PINS-1:0] sw_val_q, sw_oe_q;
    logic [NUM_PINS-1:0] drv_val, drv_oe;
    pins_t               pins_d, pins_q;

    gpom_swreg #(
        .NUM_PINS (NUM_PINS),
        .BANK_W   (BANK_W)
    ) swreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_wr_en),
        .wr_tgt  (sw_wr_tgt),
        .wr_op   (sw_wr_op),
        .wr_bank (sw_wr_bank),
        .wr_data (sw_wr_data),
        .sw_val  (sw_val_q),
        .sw_oe   (sw_oe_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpom_pin_mux #(
            .NUM_SIGS (NUM_SIGS),
            .SEL_W    (SEL_W)
        ) mux_i (
            .periph_out (periph_out),
            .periph_oe  (periph_oe),
            .sel        (cfg_sel[p*SEL_W +: SEL_W]),
            .out_inv    (cfg_out_inv[p]),
            .oe_src     (cfg_oe_src[p]),
            .oe_inv     (cfg_oe_inv[p]),
            .od         (cfg_od[p]),
            .sw_val     (sw_val_q[p]),
            .sw_oe      (sw_oe_q[p]),
            .drv_val    (drv_val[p]),
            .drv_oe     (drv_oe[p])
        );
    end

    always_comb begin
        pins_d     = pins_q;
        pins_d.val = drv_val;
        pins_d.oe  = drv_oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pin_val = pins_q.val;
    assign pin_oe  = pins_q.oe;

endmodule

// File: rtl/gpom_matrix_chk.sv
module gpom_matrix_chk #(
    parameter int NUM_PINS   = 40,
    parameter int NUM_SIGS   = 256,
    parameter int SEL_W      = 9,
    parameter int BANK_W     = 32,
    localparam int SIG_IDX_W  = $clog2(NUM_SIGS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SIGS-1:0]       periph_out,
    input logic [NUM_SIGS-1:0]       periph_oe,
    input logic [NUM_PINS*SEL_W-1:0] cfg_sel,
    input logic [NUM_PINS-1:0]       cfg_out_inv,
    input logic [NUM_PINS-1:0]       cfg_oe_src,
    input logic [NUM_PINS-1:0]       cfg_oe_inv,
    input logic [NUM_PINS-1:0]       cfg_od,
    input logic                      sw_wr_en,
    input logic                      sw_wr_tgt,
    input logic [1:0]                sw_wr_op,
    input logic                      sw_wr_bank0,
    input logic [BANK_W-1:0]         sw_wr_data,
    input logic [NUM_PINS-1:0]       sw_val_q,
    input logic [NUM_PINS-1:0]       sw_oe_q,
    input logic [NUM_PINS-1:0]       pin_val,
    input logic [NUM_PINS-1:0]       pin_oe
);

    logic past_ok;
    logic p0_periph, p0_sw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign p0_periph = (cfg_sel[SEL_W-1:0] < SEL_W'(NUM_SIGS)) && !cfg_od[0];
    assign p0_sw     = (cfg_sel[SEL_W-1:0] >= SEL_W'(NUM_SIGS)) && !cfg_od[0];

    AST_PERIPH_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(p0_periph && !cfg_out_inv[0])
        |-> pin_val[0] == $past(periph_out[cfg_sel[SIG_IDX_W-1:0]])); // R1

    AST_SW_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(p0_sw && !cfg_out_inv[0])
        |-> pin_val[0] == $past(sw_val_q[0])); // R2

    AST_VAL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(p0_periph && cfg_out_inv[0])
        |-> pin_val[0] == !$past(periph_out[cfg_sel[SIG_IDX_W-1:0]])); // R3

    AST_OE_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(p0_sw && !cfg_oe_inv[0])
        |-> pin_oe[0] == $past(sw_oe_q[0])); // R4

    AST_OE_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(p0_sw && cfg_oe_inv[0])
        |-> pin_oe[0] == !$past(sw_oe_q[0])); // R5

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pin_val & $past(cfg_od)) == '0); // R6

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(sw_wr_en && sw_wr_tgt == 1'b0 && sw_wr_op == 2'd1 && sw_wr_bank0)
        |-> (sw_val_q[BANK_W-1:0] & $past(sw_wr_data)) == $past(sw_wr_data)); // R7

    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(sw_wr_en && sw_wr_tgt == 1'b0 && sw_wr_op == 2'd2 && sw_wr_bank0)
        |-> (sw_val_q[BANK_W-1:0] & $past(sw_wr_data)) == '0); // R7

    AST_HOLD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!sw_wr_en || sw_wr_op == 2'd3)
        |-> $stable(sw_val_q) && $stable(sw_oe_q)); // R7

endmodule

bind gpom_matrix gpom_matrix_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_SIGS (NUM_SIGS),
    .SEL_W    (SEL_W),
    .BANK_W   (BANK_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_out  (periph_out),
    .periph_oe   (periph_oe),
    .cfg_sel     (cfg_sel),
    .cfg_out_inv (cfg_out_inv),
    .cfg_oe_src  (cfg_oe_src),
    .cfg_oe_inv  (cfg_oe_inv),
    .cfg_od      (cfg_od),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_tgt   (sw_wr_tgt),
    .sw_wr_op    (sw_wr_op),
    .sw_wr_bank0 (sw_wr_bank == '0),
    .sw_wr_data  (sw_wr_data),
    .sw_val_q    (sw_val_q),
    .sw_oe_q     (sw_oe_q),
    .pin_val     (pin_val),
    .pin_oe      (pin_oe)
);

// File: tb/gpom_matrix_tb_top.sv
module gpom_matrix_tb_top;

    localparam int NP    = 40;
    localparam int NS    = 256;
    localparam int SW    = 9;
    localparam int BW    = 32;
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   periph_out = '0;
    logic [NS-1:0]   periph_oe = '0;
    logic [NP*SW-1:0] cfg_sel = '0;
    logic [NP-1:0]   cfg_out_inv = '0, cfg_oe_src = '0, cfg_oe_inv = '0, cfg_od = '0;
    logic            sw_wr_en = 1'b0, sw_wr_tgt = 1'b0;
    logic [1:0]      sw_wr_op = 2'd0;
    logic            sw_wr_bank = 1'b0;
    logic [BW-1:0]   sw_wr_data = '0;
    logic [NP-1:0]   pin_val, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [NP-1:0] sw_val_m, sw_oe_m;

    always #(CLK_P/2) clk = ~clk;

    gpom_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .periph_out(periph_out), .periph_oe(periph_oe),
        .cfg_sel(cfg_sel), .cfg_out_inv(cfg_out_inv), .cfg_oe_src(cfg_oe_src),
        .cfg_oe_inv(cfg_oe_inv), .cfg_od(cfg_od), .sw_wr_en(sw_wr_en),
        .sw_wr_tgt(sw_wr_tgt), .sw_wr_op(sw_wr_op), .sw_wr_bank(sw_wr_bank),
        .sw_wr_data(sw_wr_data), .pin_val(pin_val), .pin_oe(pin_oe)
    );

    function automatic logic [NS-1:0] pat(input int seed);
        logic [NS-1:0] r;
        for (int i = 0; i < NS; i++) r[i] = ((i * 37 + seed * 11) % 5) < 2;
        return r;
    endfunction

    function automatic int sel_of(input int p);
        return int'(cfg_sel[p*SW +: SW]);
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic tgt, input logic [1:0] op, input logic bank, input logic [BW-1:0] data);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_tgt = tgt; sw_wr_op = op; sw_wr_bank = bank; sw_wr_data = data;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = 9'd256;
        cfg_oe_src = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset value", pin_val, '0);
        check("R9 reset enable", pin_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset value", pin_val, '0);
        check("R9 after reset enable", pin_oe, '0);
        cfg_oe_src = '0;
    endtask

    task automatic t_periph_route();
        for (int k = 0; k < 3; k++) begin
            logic [NP-1:0] ev, ee;
            @(negedge clk);
            for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = SW'((p * 7 + 3 + k * 50) % NS);
            cfg_sel[5*SW +: SW] = 9'd255;
            periph_out = pat(k + 1);
            periph_oe  = ~pat(k + 2);
            for (int p = 0; p < NP; p++) begin
                ev[p] = periph_out[sel_of(p)];
                ee[p] = periph_oe[sel_of(p)];
            end
            @(negedge clk);
            check("R1 peripheral value route", pin_val, ev);
            check("R4 peripheral enable route", pin_oe, ee);
        end
    endtask

    task automatic t_sw_route();
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = 9'd256;
        cfg_sel[0*SW +: SW]  = 9'd300;
        cfg_sel[39*SW +: SW] = 9'd511;
        sw_write(1'b0, 2'd0, 1'b0, 32'h1234_5678);
        sw_write(1'b0, 2'd0, 1'b1, 32'h0000_00A5);
        @(negedge clk);
        check("R2 software value route", pin_val, {8'hA5, 32'h1234_5678});
        sw_write(1'b0, 2'd1, 1'b0, 32'h0000_00F0);
        @(negedge clk);
        check("R7 set low bank", pin_val, {8'hA5, 32'h1234_56F8});
        sw_write(1'b0, 2'd2, 1'b1, 32'h0000_000F);
        @(negedge clk);
        check("R7 clear high bank", pin_val, {8'hA0, 32'h1234_56F8});
        sw_write(1'b0, 2'd3, 1'b0, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 no-effect op", pin_val, {8'hA0, 32'h1234_56F8});
        sw_write(1'b0, 2'd0, 1'b1, 32'hFFFF_FF3C);
        @(negedge clk);
        check("R7 high bank upper data ignored", pin_val, {8'h3C, 32'h1234_56F8});
        sw_write(1'b1, 2'd0, 1'b0, 32'hFFFF_0000);
        sw_write(1'b1, 2'd0, 1'b1, 32'h0000_0081);
        @(negedge clk);
        check("R4 software enable route", pin_oe, {8'h81, 32'hFFFF_0000});
        check("R7 enable write leaves value", pin_val, {8'h3C, 32'h1234_56F8});
        sw_val_m = {8'h3C, 32'h1234_56F8};
        sw_oe_m  = {8'h81, 32'hFFFF_0000};
    endtask

    task automatic t_oe_src();
        logic [NP-1:0] ev;
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = SW'(p);
        cfg_oe_src = '1;
        periph_out = pat(7);
        periph_oe  = '0;
        for (int p = 0; p < NP; p++) ev[p] = periph_out[p];
        @(negedge clk);
        check("R4 enable source register", pin_oe, sw_oe_m);
        check("R1 value with enable source", pin_val, ev);
        cfg_oe_src = '0;
    endtask

    task automatic t_invert();
        logic [NP-1:0] ev, ee;
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = SW'(p + 100);
        periph_out = pat(4);
        periph_oe  = pat(9);
        cfg_out_inv = '1;
        cfg_oe_inv  = '1;
        for (int p = 0; p < NP; p++) begin
            ev[p] = ~periph_out[p + 100];
            ee[p] = ~periph_oe[p + 100];
        end
        @(negedge clk);
        check("R3 value invert", pin_val, ev);
        check("R5 enable invert", pin_oe, ee);
        cfg_out_inv = '0;
        cfg_oe_inv  = '0;
    endtask

    task automatic t_open_drain();
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = 9'd256;
        cfg_od = '1;
        @(negedge clk);
        check("R6 open-drain value low", pin_val, '0);
        check("R6 open-drain enable", pin_oe, sw_oe_m & ~sw_val_m);
        cfg_out_inv = '1;
        @(negedge clk);
        check("R6 open-drain inverted enable", pin_oe, sw_oe_m & sw_val_m);
        cfg_od = {NP/2{2'b01}};
        @(negedge clk);
        check("R6 mixed mode value", pin_val, ~sw_val_m & {NP/2{2'b10}});
        check("R6 mixed mode enable",
              (sw_oe_m & {NP/2{2'b10}}) | (sw_oe_m & sw_val_m & {NP/2{2'b01}}) , pin_oe);
        cfg_od = '0;
        cfg_out_inv = '0;
    endtask

    task automatic t_latency();
        logic [NP-1:0] old_v, ev;
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = SW'(p);
        periph_out = '0;
        @(negedge clk);
        old_v = pin_val;
        periph_out = ~'0;
        #1;
        check("R8 no change before edge", pin_val, old_v);
        @(negedge clk);
        check("R8 one edge after input", pin_val, '1);
        @(negedge clk);
        for (int p = 0; p < NP; p++) cfg_sel[p*SW +: SW] = 9'd256;
        @(negedge clk);
        check("R8 before software write", pin_val, sw_val_m);
        sw_write(1'b0, 2'd0, 1'b0, 32'hEDCB_A907);
        ev = {sw_val_m[39:32], 32'hEDCB_A907};
        check("R8 one edge after write still old", pin_val, sw_val_m);
        @(negedge clk);
        check("R8 two edges after write", pin_val, ev);
    endtask

    initial begin
        t_reset();
        t_periph_route();
        t_sw_route();
        t_oe_src();
        t_invert();
        t_open_drain();
        t_latency();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule